// File: doc/BRIEF.md
# Shared-Line Serial EEPROM Read Master

This block is the host side of a read from a small serial EEPROM whose data input and data output pins are wired together onto one bidirectional line. On a start request it raises chip select, generates the serial clock and presents a read frame on the line: a start bit of 1, the two-bit read code `10`, then a 6-bit word address, most significant bit first. The memory captures each bit on a rising clock edge. From the rising edge that clocks in the last address bit, the memory begins driving the line with one leading zero and then 16 data bits. The host must therefore release its own line driver at a controlled point. It does so through an active-low driver enable that goes inactive one fast half-period after that last rising edge, which serves as the hold time.

The read-back is slow, because the line is driven by the memory through a series resistor into the bus capacitance. For that reason the clock runs at a second, slower rate, set by its own half-period parameter, from the last address edge to the end of the word. The host samples the line in the last system cycle before each rising edge. The first sample is the leading zero, and a flag is raised if it reads as 1. The next sixteen samples form the word. After the sixteenth data bit the block drops chip select without issuing another edge, and it presents the word with a one-cycle valid pulse.

The controller is a six-state machine. `ST_IDLE` moves to `ST_CMD_LO` on start. `ST_CMD_LO` and `ST_CMD_HI` alternate, each for `FAST_HALF` cycles, and the next frame bit is shifted on each high-to-low transition. After the ninth high half, `ST_CMD_HI` moves to `ST_RD_LO`. `ST_RD_LO` and `ST_RD_HI` alternate, each for `SLOW_HALF` cycles, with a sample on the last cycle of every `ST_RD_LO`. After the seventeenth sample, `ST_RD_LO` moves to `ST_DONE`, which lasts one cycle and returns to `ST_IDLE`.

Top module: `sdl_rd_master`

## Requirements
- R1: Out of reset and whenever idle, chip select is 0, the serial clock is 0, the driver enable `sd_oe_n` is 1 (driver off), and `busy`, `rd_valid`, `zero_err` and `rd_word` are all 0.
- R2: The command frame is 9 bits, in this order: 1, 1, 0, then A5 down to A0. Each bit is on `sd_out` before its rising clock edge and stays unchanged for the whole high half that follows.
- R3: During the command bits, each low half and each high half of the serial clock lasts exactly `FAST_HALF` system cycles (default 2).
- R4: `sd_oe_n` is 0 from the moment chip select rises until the falling clock edge that ends the A0 high half, which is `FAST_HALF` cycles after the ninth rising edge. It is 1 for the rest of the transfer.
- R5: After the ninth rising edge, each low half and each high half lasts exactly `SLOW_HALF` system cycles (default 6), including the final low half that ends with chip select falling.
- R6: The line is sampled in the last system cycle of each low half after the ninth edge. The first sample is the leading zero. The next 16 samples are D15 down to D0, and they form `rd_word` with the first data sample in bit 15.
- R7: `zero_err` becomes 1 if the leading-zero sample reads 1. It keeps its value until the next accepted start, which clears it.
- R8: Exactly 25 rising edges occur per transfer. Chip select falls after the sixteenth data sample, and `rd_valid` is high for exactly one cycle while chip select and the clock are low.
- R9: `busy` is 1 from the cycle after an accepted start through the `rd_valid` cycle. A `start` while busy is ignored: it neither changes the address being sent nor begins another transfer.
- R10: `rd_word` changes only in the cycle where `rd_valid` is high, and it keeps its value between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read; accepted only when not busy |
| addr | input | ADDR_W | Word address, captured with an accepted start |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle pulse, `rd_word` is new |
| rd_word | output | DATA_W | Last word read |
| zero_err | output | 1 | Leading-zero sample of the last transfer read 1 |
| sc_cs | output | 1 | Memory chip select, active high |
| sc_clk | output | 1 | Serial clock to the memory |
| sd_out | output | 1 | Host data toward the shared line |
| sd_oe_n | output | 1 | Active-low enable of the host line driver |
| sd_in | input | 1 | Shared line as seen by the host receiver |

## Verification
The properties assume a clean `start` input and an `addr` that is held only during the start cycle. They assume nothing about `sd_in` beyond its being a binary level in the cycle it is sampled. The bench drives `start` and `addr` on the falling system edge. Its memory model updates the line only half a system cycle after it observes a rising serial edge, so every sampled value has been settled for several slow cycles. The random mix keeps the leading-one fault rare, and it injects a start while busy only once the frame is already under way.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD_LO = 3'd1,
        ST_CMD_HI = 3'd2,
        ST_RD_LO  = 3'd3,
        ST_RD_HI  = 3'd4,
        ST_DONE   = 3'd5
    } sdl_state_e;

    // Start bit followed by the two-bit read code
    localparam int          OP_W      = 3;
    localparam logic [OP_W-1:0] RD_OPCODE = 3'b110;

endpackage

// File: rtl/sdl_half_timer.sv
// Reloadable down-counter that times one serial-clock half-period.
module sdl_half_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/sdl_cmd_shifter.sv
// Holds the outgoing read frame; MSB is the bit on the line.
module sdl_cmd_shifter
    import sdl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [ADDR_W-1:0] addr,
    output logic              bit_out
);

    localparam int FRAME_W = OP_W + ADDR_W;

    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= {RD_OPCODE, addr};
        end else if (shift) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign bit_out = frame_q[FRAME_W-1];

endmodule

// File: rtl/sdl_rx_shifter.sv
// Collects the leading-zero check and the data bits from the shared line.
module sdl_rx_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              lead,
    input  logic              commit,
    input  logic              din,
    output logic [DATA_W-1:0] word,
    output logic              lead_err
);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] word_q;
    logic              err_q;
    logic [DATA_W-1:0] sh_next;

    assign sh_next = {sh_q[DATA_W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            err_q  <= 1'b0;
        end else if (clear) begin
            sh_q   <= '0;
            err_q  <= 1'b0;
        end else if (sample) begin
            if (lead) begin
                err_q <= din;
            end else begin
                sh_q  <= sh_next;
            end
        end
    end

    // Output word is updated only with the final data sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (sample && commit) begin
            word_q <= sh_next;
        end
    end

    assign word     = word_q;
    assign lead_err = err_q;

endmodule

// File: rtl/sdl_rd_master.sv
module sdl_rd_master
    import sdl_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word,
    output logic              zero_err,
    output logic              sc_cs,
    output logic              sc_clk,
    output logic              sd_out,
    output logic              sd_oe_n,
    input  logic              sd_in
);

    localparam int CMD_BITS = OP_W + ADDR_W;
    localparam int HALF_MAX = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);
    localparam int BIT_W    = $clog2(CMD_BITS);
    localparam int RD_W     = $clog2(DATA_W + 1);

    localparam logic [CNT_W-1:0] FAST_LD  = CNT_W'(FAST_HALF - 1);
    localparam logic [CNT_W-1:0] SLOW_LD  = CNT_W'(SLOW_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CMD_BITS - 1);
    localparam logic [RD_W-1:0]  RD_LAST  = RD_W'(DATA_W);

    sdl_state_e st_q, st_nxt;

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_exp;
    logic             cmd_load;
    logic             cmd_shift;
    logic             cmd_bit;
    logic             rx_clear;
    logic             rx_sample;
    logic             rx_lead;
    logic             rx_commit;
    logic             rd_inc;
    logic [BIT_W-1:0] bit_idx_q;
    logic [RD_W-1:0]  rd_idx_q;

    // ---------------- State register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // ---------------- Next state and datapath controls ----------------
    always_comb begin
        st_nxt    = st_q;
        t_load    = 1'b0;
        t_val     = FAST_LD;
        cmd_load  = 1'b0;
        cmd_shift = 1'b0;
        rx_clear  = 1'b0;
        rx_sample = 1'b0;
        rx_lead   = 1'b0;
        rx_commit = 1'b0;
        rd_inc    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_nxt   = ST_CMD_LO;
                    t_load   = 1'b1;
                    t_val    = FAST_LD;
                    cmd_load = 1'b1;
                    rx_clear = 1'b1;
                end
            end
            ST_CMD_LO: begin
                if (t_exp) begin
                    st_nxt = ST_CMD_HI;
                    t_load = 1'b1;
                    t_val  = FAST_LD;
                end
            end
            ST_CMD_HI: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (bit_idx_q == BIT_LAST) begin
                        // A0 hold elapsed: release the line, switch to slow rate
                        st_nxt = ST_RD_LO;
                        t_val  = SLOW_LD;
                    end else begin
                        st_nxt    = ST_CMD_LO;
                        t_val     = FAST_LD;
                        cmd_shift = 1'b1;
                    end
                end
            end
            ST_RD_LO: begin
                if (t_exp) begin
                    rx_sample = 1'b1;
                    rx_lead   = (rd_idx_q == '0);
                    if (rd_idx_q == RD_LAST) begin
                        st_nxt    = ST_DONE;
                        rx_commit = 1'b1;
                    end else begin
                        st_nxt = ST_RD_HI;
                        t_load = 1'b1;
                        t_val  = SLOW_LD;
                    end
                end
            end
            ST_RD_HI: begin
                if (t_exp) begin
                    st_nxt = ST_RD_LO;
                    t_load = 1'b1;
                    t_val  = SLOW_LD;
                    rd_inc = 1'b1;
                end
            end
            ST_DONE: begin
                st_nxt = ST_IDLE;
            end
            default: begin
                st_nxt = ST_IDLE;
            end
        endcase
    end

    // ---------------- Bit counters ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            rd_idx_q  <= '0;
        end else begin
            if (cmd_load) begin
                bit_idx_q <= '0;
                rd_idx_q  <= '0;
            end else begin
                if (cmd_shift) begin
                    bit_idx_q <= bit_idx_q + 1'b1;
                end
                if (rd_inc) begin
                    rd_idx_q <= rd_idx_q + 1'b1;
                end
            end
        end
    end

    // ---------------- Outputs decoded from state ----------------
    always_comb begin
        sc_cs    = 1'b0;
        sc_clk   = 1'b0;
        sd_out   = 1'b0;
        sd_oe_n  = 1'b1;
        busy     = 1'b1;
        rd_valid = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_CMD_LO: begin
                sc_cs   = 1'b1;
                sd_out  = cmd_bit;
                sd_oe_n = 1'b0;
            end
            ST_CMD_HI: begin
                sc_cs   = 1'b1;
                sc_clk  = 1'b1;
                sd_out  = cmd_bit;
                sd_oe_n = 1'b0;
            end
            ST_RD_LO: begin
                sc_cs = 1'b1;
            end
            ST_RD_HI: begin
                sc_cs  = 1'b1;
                sc_clk = 1'b1;
            end
            ST_DONE: begin
                rd_valid = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // ---------------- Sub-blocks ----------------
    sdl_half_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_exp)
    );

    sdl_cmd_shifter #(
        .ADDR_W (ADDR_W)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_load),
        .shift   (cmd_shift),
        .addr    (addr),
        .bit_out (cmd_bit)
    );

    sdl_rx_shifter #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_clear),
        .sample   (rx_sample),
        .lead     (rx_lead),
        .commit   (rx_commit),
        .din      (sd_in),
        .word     (rd_word),
        .lead_err (zero_err)
    );

endmodule

// File: rtl/sdl_rd_master_chk.sv
module sdl_rd_master_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_word,
    input logic              zero_err,
    input logic              sc_cs,
    input logic              sc_clk,
    input logic              sd_out,
    input logic              sd_oe_n,
    input logic              sd_in
);

    // R1 / R4: driver is off whenever the memory is deselected
    p_oe_off_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_cs |-> sd_oe_n);

    // R1: serial clock parked low while deselected
    p_clk_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_cs |-> !sc_clk);

    // R2: a driven command bit does not change during its high half
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_oe_n && sc_clk) |-> $stable(sd_out));

    // R4: the driver is released only together with a falling clock edge
    p_oe_rel_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe_n) |-> $fell(sc_clk));

    // R8: valid is a single-cycle pulse
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8: valid appears only after chip select has dropped
    p_valid_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!sc_cs && !sc_clk && $fell(sc_cs)));

    // R9: an accepted start makes the block busy next cycle
    p_start_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && sc_cs));

    // R7: the leading-zero flag is clear when a new transfer begins
    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !zero_err);

    // R10: the output word moves only with the valid pulse
    p_word_only_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_word) |-> rd_valid);

endmodule

bind sdl_rd_master sdl_rd_master_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .addr     (addr),
    .busy     (busy),
    .rd_valid (rd_valid),
    .rd_word  (rd_word),
    .zero_err (zero_err),
    .sc_cs    (sc_cs),
    .sc_clk   (sc_clk),
    .sd_out   (sd_out),
    .sd_oe_n  (sd_oe_n),
    .sd_in    (sd_in)
);

// File: tb/sdl_rd_master_test.sv
module sdl_rd_master_test;

    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;
    localparam int FAST_HALF = 2;
    localparam int SLOW_HALF = 6;
    localparam int CMD_BITS  = 9;
    localparam int ALL_EDGES = CMD_BITS + DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              busy, rd_valid, zero_err, sc_cs, sc_clk, sd_out, sd_oe_n;
    logic [DATA_W-1:0] rd_word;
    logic              sd_in;

    always #2 clk = ~clk;

    sdl_rd_master #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .FAST_HALF (FAST_HALF), .SLOW_HALF (SLOW_HALF)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start (start), .addr (addr),
        .busy (busy), .rd_valid (rd_valid), .rd_word (rd_word),
        .zero_err (zero_err), .sc_cs (sc_cs), .sc_clk (sc_clk),
        .sd_out (sd_out), .sd_oe_n (sd_oe_n), .sd_in (sd_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // ---------------- Memory model and line monitor ----------------
    logic [DATA_W-1:0] salt;
    logic [DATA_W-1:0] cur_word;
    bit                lead_one;
    bit                mem_drv;
    logic              mem_q;

    assign sd_in = !sd_oe_n ? sd_out : (mem_drv ? mem_q : 1'b1);

    bit   prev_clk, prev_cs, prev_valid;
    int   k_edge, lo_w, hi_w, cs_rises;
    logic [CMD_BITS-1:0] cmd_cap;
    bit   err_fast, err_slow, err_oe, err_hold;
    int   end_edges, end_lo;
    int   val_len;
    bit   val_done;
    logic [DATA_W-1:0] val_word;
    bit   val_err;

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] x;
        x = (DATA_W'(a) * 16'hA5C3) + 16'h1357;
        return x ^ {a, 10'h2B5} ^ salt;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_clk = 0; prev_cs = 0; prev_valid = 0;
            k_edge = 0; lo_w = 0; hi_w = 0; mem_drv = 0; mem_q = 0;
        end else begin
            if (sc_cs && !prev_cs) begin
                k_edge = 0; lo_w = 1; hi_w = 0; cmd_cap = '0;
                cs_rises++;
            end else if (sc_cs && sc_clk && !prev_clk) begin
                k_edge++;
                if (k_edge <= CMD_BITS) begin
                    if (lo_w != FAST_HALF) err_fast = 1;
                    cmd_cap = {cmd_cap[CMD_BITS-2:0], sd_out};
                end else if (lo_w != SLOW_HALF) err_slow = 1;
                if (k_edge == CMD_BITS) begin
                    mem_drv = 1; mem_q = lead_one;
                end else if (k_edge > CMD_BITS && k_edge <= ALL_EDGES) begin
                    mem_q = cur_word[ALL_EDGES - k_edge];
                end
                hi_w = 1;
            end else if (sc_cs && !sc_clk && prev_clk) begin
                if (k_edge <= CMD_BITS) begin
                    if (hi_w != FAST_HALF) err_fast = 1;
                end else if (hi_w != SLOW_HALF) err_slow = 1;
                lo_w = 1;
            end else if (sc_cs) begin
                if (sc_clk) hi_w++; else lo_w++;
            end
            if (sc_cs) begin
                if (sd_oe_n != !((k_edge < CMD_BITS) || (k_edge == CMD_BITS && sc_clk)))
                    err_oe = 1;
                if (sc_clk && k_edge <= CMD_BITS && sd_out != cmd_cap[0]) err_hold = 1;
            end
            if (!sc_cs && prev_cs) begin
                end_edges = k_edge; end_lo = lo_w; mem_drv = 0;
            end
            if (rd_valid) begin
                if (!prev_valid) begin
                    val_len = 1; val_word = rd_word; val_err = zero_err;
                    if (sc_cs || sc_clk) val_len = 99;
                end else val_len++;
            end else if (prev_valid) val_done = 1;
            prev_clk = sc_clk; prev_cs = sc_cs; prev_valid = rd_valid;
        end
    end

    // ---------------- Checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input bit lead1, input bit intrude);
        int rises0;
        cur_word = mem_word(a);
        lead_one = lead1;
        err_fast = 0; err_slow = 0; err_oe = 0; err_hold = 0;
        val_done = 0; val_len = 0;
        rises0 = cs_rises;
        @(negedge clk); start = 1'b1; addr = a;
        @(negedge clk); start = 1'b0; addr = ADDR_W'($urandom);
        #1 chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
        if (intrude) begin
            repeat (30) @(negedge clk);
            start = 1'b1; addr = ~a;
            @(negedge clk); start = 1'b0;
        end
        forever begin
            @(negedge clk); #1;
            if (val_done) break;
        end
        chk(cmd_cap == {3'b110, a}, "R2 command frame", int'(cmd_cap), int'({3'b110, a}));
        chk(!err_hold, "R2 bit hold in high half", int'(err_hold), 0);
        chk(!err_fast, "R3 fast half-periods", int'(err_fast), 0);
        chk(!err_oe, "R4 driver enable window", int'(err_oe), 0);
        chk(!err_slow && end_lo == SLOW_HALF, "R5 slow half-periods", end_lo, SLOW_HALF);
        chk(end_edges == ALL_EDGES, "R8 rising edge count", end_edges, ALL_EDGES);
        chk(val_len == 1, "R8 valid pulse length", val_len, 1);
        chk(val_word == cur_word, "R6 assembled word", int'(val_word), int'(cur_word));
        chk(val_err == lead1, "R7 leading zero flag", int'(val_err), int'(lead1));
        chk(cs_rises == rises0 + 1, "R9 one transfer per start", cs_rises - rises0, 1);
        repeat (10) @(negedge clk);
        #1;
        chk(!busy && !sc_cs && cs_rises == rises0 + 1, "R9 idle after transfer",
            int'(busy), 0);
        chk(rd_word == cur_word && zero_err == lead1, "R10 word and flag held",
            int'(rd_word), int'(cur_word));
    endtask

    // ---------------- Stimulus ----------------
    initial begin
        void'($urandom(32'h5EED_1234));
        salt = 16'h0;
        cs_rises = 0;
        repeat (3) @(negedge clk);
        chk(!sc_cs && !sc_clk && sd_oe_n && !busy && !rd_valid, "R1 outputs in reset",
            int'({sc_cs, sc_clk, sd_oe_n, busy, rd_valid}), 5'b00100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #1 chk(!sc_cs && !sc_clk && sd_oe_n && !busy && !rd_valid && !zero_err
               && rd_word == '0, "R1 idle after reset",
               int'({sc_cs, sc_clk, sd_oe_n, busy, rd_valid, zero_err}), 6'b001000);

        // Directed corners
        do_read(6'd0,  1'b0, 1'b0);
        do_read(6'd63, 1'b0, 1'b0);   // all address bits 1, A0 odd
        do_read(6'd1,  1'b0, 1'b0);   // only A0 set
        do_read(6'd42, 1'b1, 1'b0);   // faulty leading bit
        do_read(6'd21, 1'b0, 1'b0);   // flag must clear again
        do_read(6'd5,  1'b0, 1'b1);   // start pulsed while busy
        salt = 16'hFFFF;
        do_read(6'd62, 1'b0, 1'b0);   // word of all ones region

        // Random mix
        for (int i = 0; i < 24; i++) begin
            salt = DATA_W'($urandom);
            do_read(ADDR_W'($urandom), ($urandom % 6) == 0, ($urandom % 5) == 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule